// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block is the command front end of a byte-wide parallel flash with a 20-bit address and an 8-bit data bus. It samples the chip-enable, write-enable and output-enable strobes on a system clock and turns each valid write strobe into one bus cycle. A stream of such cycles is matched against keyed unlock sequences. The sequences select one of four actions: a single-byte program, a whole-array erase, setting a lock on a 16 KB boot sector, or entering and leaving an identification mode. Approved program and erase requests go out as one-cycle pulses to an execution engine, which is not part of this block.

The boot sector sits at the bottom or the top of the array, chosen by a parameter. Once locked, it refuses program requests and is marked to be spared by an erase. An override input, standing in for a high voltage on the reset pin, suspends the lock for as long as it is held. In identification mode, reads return a maker code, a variant-specific device code and the lock state. The storage array, the high-voltage detector and the supply monitor are outside the block and appear only as simple inputs.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After power-on reset (`rst_n` low) no request pulse is active, `boot_locked` and `id_active` are 0 and `id_dout` is 00.
- R2: A bus cycle is the time during which `ce_n` and `we_n` are both sampled low. The address is taken from the first such sample and the data from the last one. The cycle takes effect on the first clock edge at which either strobe is sampled high again.
- R3: The writes AA to 5555, 55 to 2AAA, A0 to 5555, then a target write produce a one-cycle `prog_req` carrying the target address and data, in the cycle after the target cycle ends. Unlock steps compare only address bits 14..0.
- R4: The writes AA/5555, 55/2AAA, 80/5555, AA/5555, 55/2AAA, 10/5555 produce a one-cycle `erase_req`. Along with it, `erase_keep_boot` is 1 exactly when the sector was locked and `lock_override` was low at that moment.
- R5: The same six writes ending in 40/5555 set `boot_locked`. The flag then stays 1 until power-on reset.
- R6: A program target inside the boot sector (00000–03FFF for the bottom variant, FC000–FFFFF for the top variant) gives no `prog_req` while the sector is locked and `lock_override` is 0. With `lock_override` at 1 the target is programmed, and the lock applies again once the input falls.
- R7: The writes AA/5555, 55/2AAA, 90/5555 set `id_active`.
- R8: While `id_active` is 1 and a read is in progress (`ce_n`=0, `oe_n`=0, `we_n`=1), `id_dout` returns:
  - 1F at address 00000;
  - 23 (bottom variant) or 27 (top variant) at 00001;
  - the lock flag in bit 0 at the sector base plus 2;
  - 00 at any other address.

  At all other times `id_dout` is 00.
- R9: A write of F0 to any address leaves identification mode, including F0/5555 after the two unlock writes. The one exception is a write taken as the target of a program.
- R10: A strobe sampled low for fewer than `GLITCH_CYC` clocks is not a bus cycle and changes nothing.
- R11: A strobe during which `oe_n` was sampled low is refused. So is a strobe that ends while `supply_ok` is 0.
- R12: A write that does not match the next expected step returns the decoder to idle with no request and no mode or lock change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 20 | Bus address |
| din | input | 8 | Write data |
| supply_ok | input | 1 | Supply monitor: writes accepted only when 1 |
| lock_override | input | 1 | Suspends the boot-sector lock while 1 |
| id_dout | output | 8 | Identification read data |
| id_active | output | 1 | Identification mode is on |
| boot_locked | output | 1 | Sticky boot-sector lock flag |
| prog_req | output | 1 | One-cycle byte program request |
| prog_addr | output | 20 | Program target address |
| prog_data | output | 8 | Program data |
| erase_req | output | 1 | One-cycle chip erase request |
| erase_keep_boot | output | 1 | The erase must spare the boot sector |

## Verification
Some properties are checked on every cycle:
- the lock flag never falls;
- no program request reaches a locked sector without the override;
- the spare-boot marker on each erase matches the lock and override state one cycle earlier;
- a request is only ever issued right after a strobe ends;
- identification mode only switches on after a 90 write.

Other behaviours need the bench's scenarios and its cycle-accurate reference model:
- the full multi-step sequences;
- aborting a sequence on a wrong step;
- glitch and output-enable refusal;
- the two ways of leaving identification mode;
- which address and which data are captured when the two strobes are staggered.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW         = 20,
  parameter int BOOT_AW    = 14,
  parameter bit TOP_BOOT   = 1'b0,
  parameter int GLITCH_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic          supply_ok,
  input  logic          lock_override,
  output logic [7:0]    id_dout,
  output logic          id_active,
  output logic          boot_locked,
  output logic          prog_req,
  output logic [AW-1:0] prog_addr,
  output logic [7:0]    prog_data,
  output logic          erase_req,
  output logic          erase_keep_boot
);

  localparam int CW   = $clog2(GLITCH_CYC + 1);
  localparam int TAGW = AW - BOOT_AW;
  localparam logic [CW-1:0] CNT_MAX = CW'(GLITCH_CYC);
  localparam logic [AW-1:0] BOOT_BASE = TOP_BOOT ? {{TAGW{1'b1}}, {BOOT_AW{1'b0}}} : '0;
  localparam logic [AW-1:0] LOCK_ADDR = BOOT_BASE | AW'(2);
  localparam logic [7:0] MAKER   = 8'h1F;
  localparam logic [7:0] DEVCODE = TOP_BOOT ? 8'h27 : 8'h23;
  localparam logic [14:0] KEY_A = 15'h5555;
  localparam logic [14:0] KEY_B = 15'h2AAA;

  typedef enum logic [2:0] {S_IDLE, S_UN1, S_UN2, S_PROG, S_EX1, S_EX2, S_EX3} step_t;

  function automatic logic in_boot(input logic [AW-1:0] a);
    if (TOP_BOOT) return &a[AW-1:BOOT_AW];
    else          return ~|a[AW-1:BOOT_AW];
  endfunction

  logic          act, act_q, oe_low;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_lat;
  logic [7:0]    d_lat;

  assign act = !ce_n && !we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt    <= '0;
      oe_low <= 1'b0;
      a_lat  <= '0;
      d_lat  <= '0;
    end else begin
      act_q <= act;
      if (act) begin
        d_lat <= din;
        if (!act_q) begin
          a_lat  <= addr;
          cnt    <= CW'(1);
          oe_low <= !oe_n;
        end else begin
          if (cnt != CNT_MAX) cnt <= cnt + CW'(1);
          if (!oe_n) oe_low <= 1'b1;
        end
      end
    end
  end

  logic wr_fire, at_a, at_b, guard;
  assign wr_fire = act_q && !act && (cnt == CNT_MAX) && !oe_low && supply_ok;
  assign at_a    = a_lat[14:0] == KEY_A;
  assign at_b    = a_lat[14:0] == KEY_B;
  assign guard   = boot_locked && !lock_override;

  step_t st, st_n;
  logic  fire_prog, fire_erase, set_lock, id_set, id_clr;

  assign id_clr = wr_fire && (st != S_PROG) && (d_lat == 8'hF0);

  always_comb begin
    st_n       = st;
    fire_prog  = 1'b0;
    fire_erase = 1'b0;
    set_lock   = 1'b0;
    id_set     = 1'b0;
    if (wr_fire) begin
      st_n = S_IDLE;
      case (st)
        S_IDLE: if (at_a && d_lat == 8'hAA) st_n = S_UN1;
        S_UN1:  if (at_b && d_lat == 8'h55) st_n = S_UN2;
        S_UN2:
          if (at_a) begin
            case (d_lat)
              8'hA0:   st_n = S_PROG;
              8'h80:   st_n = S_EX1;
              8'h90:   id_set = 1'b1;
              default: st_n = S_IDLE;
            endcase
          end
        S_PROG: fire_prog = !(in_boot(a_lat) && guard);
        S_EX1:  if (at_a && d_lat == 8'hAA) st_n = S_EX2;
        S_EX2:  if (at_b && d_lat == 8'h55) st_n = S_EX3;
        S_EX3:
          if (at_a) begin
            fire_erase = d_lat == 8'h10;
            set_lock   = d_lat == 8'h40;
          end
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st              <= S_IDLE;
      prog_req        <= 1'b0;
      prog_addr       <= '0;
      prog_data       <= '0;
      erase_req       <= 1'b0;
      erase_keep_boot <= 1'b0;
      boot_locked     <= 1'b0;
      id_active       <= 1'b0;
    end else begin
      st        <= st_n;
      prog_req  <= fire_prog;
      erase_req <= fire_erase;
      if (fire_prog) begin
        prog_addr <= a_lat;
        prog_data <= d_lat;
      end
      if (fire_erase) erase_keep_boot <= guard;
      if (set_lock) boot_locked <= 1'b1;
      if (id_set) id_active <= 1'b1;
      else if (id_clr) id_active <= 1'b0;
    end
  end

  logic rd_en;
  assign rd_en = id_active && !ce_n && !oe_n && we_n;

  always_comb begin
    id_dout = 8'h00;
    if (rd_en) begin
      if (addr == '0)             id_dout = MAKER;
      else if (addr == AW'(1))    id_dout = DEVCODE;
      else if (addr == LOCK_ADDR) id_dout = {7'b0, boot_locked};
    end
  end

  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_locked |=> boot_locked);

  // R6
  boot_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && in_boot(prog_addr)) |-> $past(!boot_locked || lock_override));

  // R4
  erase_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> (erase_keep_boot == $past(boot_locked && !lock_override)));

  // R2
  req_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req || erase_req) |-> $past(act_q && !act));

  // R3
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, erase_req}));

  // R7
  id_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_active) |-> $past(d_lat) == 8'h90);

endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int GL = 2;

  logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, oe_n = 1;
  logic [19:0] addr = '0;
  logic [7:0]  din = '0;
  logic supply_ok = 1, lock_override = 0;
  logic [7:0] id_dout;
  logic id_active, boot_locked, prog_req, erase_req, erase_keep_boot;
  logic [19:0] prog_addr;
  logic [7:0]  prog_data;

  flash_cmd_decoder #(.GLITCH_CYC(GL)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .supply_ok(supply_ok), .lock_override(lock_override),
    .id_dout(id_dout), .id_active(id_active), .boot_locked(boot_locked),
    .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_req(erase_req), .erase_keep_boot(erase_keep_boot));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: history of accepted writes, behavioural
  int hist_a[$];
  int hist_d[$];
  bit m_was, m_oel, m_prog, m_erase, m_keep, m_lock, m_id;
  int m_hold;
  logic [19:0] m_a, m_pa;
  logic [7:0]  m_d, m_pd;

  function automatic bit hmatch(int i, int a, int d);
    return hist_a[i] == a && hist_d[i] == d;
  endfunction

  function automatic bit in_boot_m(logic [19:0] a);
    return a < 20'h04000;
  endfunction

  task automatic model_write(input logic [19:0] a, input logic [7:0] d);
    int n;
    bit ok;
    int a15;
    a15 = int'(a[14:0]);
    if (hist_a.size() == 3 && hist_d[2] == 'hA0) begin
      if (!(in_boot_m(a) && m_lock && !lock_override)) begin
        m_prog = 1; m_pa = a; m_pd = d;
      end
      hist_a.delete(); hist_d.delete();
      return;
    end
    if (d == 8'hF0) m_id = 0;
    hist_a.push_back(a15); hist_d.push_back(int'(d));
    n = hist_a.size();
    ok = hmatch(0, 'h5555, 'hAA);
    if (n >= 2) ok = ok && hmatch(1, 'h2AAA, 'h55);
    if (n >= 3) ok = ok && hist_a[2] == 'h5555 &&
                     (hist_d[2] == 'hA0 || hist_d[2] == 'h80 || hist_d[2] == 'h90);
    if (n >= 4) ok = ok && hist_d[2] == 'h80 && hmatch(3, 'h5555, 'hAA);
    if (n >= 5) ok = ok && hmatch(4, 'h2AAA, 'h55);
    if (n == 3 && ok && hist_d[2] == 'h90) begin m_id = 1; ok = 0; end
    if (n == 6 && ok) begin
      if (hmatch(5, 'h5555, 'h10)) begin m_erase = 1; m_keep = m_lock && !lock_override; end
      if (hmatch(5, 'h5555, 'h40)) m_lock = 1;
      ok = 0;
    end
    if (!ok) begin hist_a.delete(); hist_d.delete(); end
  endtask

  always @(posedge clk) begin
    m_prog = 0; m_erase = 0;
    if (!rst_n) begin
      m_was = 0; m_oel = 0; m_hold = 0; m_lock = 0; m_id = 0; m_keep = 0;
      hist_a.delete(); hist_d.delete();
    end else if (!ce_n && !we_n) begin
      if (!m_was) begin m_hold = 1; m_a = addr; m_oel = !oe_n; end
      else begin m_hold++; if (!oe_n) m_oel = 1; end
      m_d = din; m_was = 1;
    end else begin
      if (m_was && m_hold >= GL && !m_oel && supply_ok) model_write(m_a, m_d);
      m_was = 0;
    end
  end

  function automatic logic [7:0] exp_id();
    if (!(m_id && !ce_n && !oe_n && we_n)) return 8'h00;
    if (addr == 20'h00000) return 8'h1F;
    if (addr == 20'h00001) return 8'h23;
    if (addr == 20'h00002) return {7'b0, m_lock};
    return 8'h00;
  endfunction

  int prog_cnt = 0, erase_cnt = 0;
  logic [19:0] last_pa;
  logic [7:0]  last_pd;
  logic        last_keep;

  always @(negedge clk) if (rst_n) begin
    chk("R3 prog_req", prog_req, m_prog);
    if (m_prog) begin
      chk("R3 prog_addr", prog_addr, m_pa);
      chk("R3 prog_data", prog_data, m_pd);
    end
    chk("R4 erase_req", erase_req, m_erase);
    if (m_erase) chk("R4 erase_keep_boot", erase_keep_boot, m_keep);
    chk("R5 boot_locked", boot_locked, m_lock);
    chk("R7 id_active", id_active, m_id);
    chk("R8 id_dout", id_dout, exp_id());
    if (prog_req) begin prog_cnt++; last_pa = prog_addr; last_pd = prog_data; end
    if (erase_req) begin erase_cnt++; last_keep = erase_keep_boot; end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [19:0] a, input logic [7:0] d, input int len = 3, input bit oe = 1);
    tick();
    addr = a; din = d; ce_n = 0; we_n = 0; oe_n = oe;
    repeat (len - 1) tick();
    tick();
    we_n = 1; ce_n = 1; oe_n = 1; din = 8'hEE;
    tick();
  endtask

  task automatic unlock();
    wr(20'h05555, 8'hAA);
    wr(20'h02AAA, 8'h55);
  endtask

  task automatic prog(input logic [19:0] a, input logic [7:0] d);
    unlock(); wr(20'h05555, 8'hA0); wr(a, d);
  endtask

  task automatic six(input logic [7:0] last);
    unlock(); wr(20'h05555, 8'h80); unlock(); wr(20'h05555, last);
  endtask

  task automatic rd(input logic [19:0] a, output logic [7:0] v);
    tick();
    addr = a; ce_n = 0; oe_n = 0; we_n = 1;
    @(negedge clk); v = id_dout;
    #1; ce_n = 1; oe_n = 1;
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p0;
    logic [7:0] v;
    repeat (3) tick();
    chk("R1 prog_req", prog_req, 0);
    chk("R1 boot_locked", boot_locked, 0);
    chk("R1 id_active", id_active, 0);
    chk("R1 id_dout", id_dout, 0);
    rst_n = 1;
    tick();

    // R3: high address bits ignored on unlock steps
    p0 = prog_cnt;
    wr(20'hF5555, 8'hAA); wr(20'h3AAAA, 8'h55); wr(20'h85555, 8'hA0); wr(20'h12345, 8'h5A);
    chk("R3 count", prog_cnt - p0, 1);
    chk("R3 addr", last_pa, 20'h12345);
    chk("R3 data", last_pd, 8'h5A);

    // R10: glitch target ignored, next real write is the target
    p0 = prog_cnt;
    unlock(); wr(20'h05555, 8'hA0); wr(20'h00777, 8'h11, 1);
    chk("R10 glitch ignored", prog_cnt - p0, 0);
    wr(20'h00778, 8'h22);
    chk("R10 following write", last_pa, 20'h00778);

    // R11: oe low and supply low refuse
    p0 = prog_cnt;
    unlock(); wr(20'h05555, 8'hA0); wr(20'h00900, 8'h33, 3, 0);
    chk("R11 oe refused", prog_cnt - p0, 0);
    supply_ok = 0; wr(20'h00901, 8'h34); supply_ok = 1;
    chk("R11 supply refused", prog_cnt - p0, 0);
    wr(20'h00902, 8'h35);
    chk("R11 then accepted", last_pd, 8'h35);

    // R12: wrong step aborts
    p0 = prog_cnt;
    unlock(); wr(20'h05555, 8'h77); wr(20'h00100, 8'h33);
    chk("R12 abort", prog_cnt - p0, 0);
    chk("R12 no id", id_active, 0);

    // R2: staggered strobes
    p0 = prog_cnt;
    unlock(); wr(20'h05555, 8'hA0);
    tick(); ce_n = 0; we_n = 1; addr = 20'h00500;
    tick(); addr = 20'h00600; we_n = 0; din = 8'h11;
    tick(); din = 8'h22;
    tick(); din = 8'hC3;
    tick(); ce_n = 1; din = 8'h99;
    tick(); we_n = 1;
    tick();
    chk("R2 count", prog_cnt - p0, 1);
    chk("R2 later-fall address", last_pa, 20'h00600);
    chk("R2 earlier-rise data", last_pd, 8'hC3);

    // R4: erase unlocked
    p0 = erase_cnt;
    six(8'h10);
    chk("R4 erase", erase_cnt - p0, 1);
    chk("R4 keep unlocked", last_keep, 0);

    // R7 / R8 / R9
    unlock(); wr(20'h05555, 8'h90);
    chk("R7 entry", id_active, 1);
    rd(20'h00000, v); chk("R8 maker", v, 8'h1F);
    rd(20'h00001, v); chk("R8 device", v, 8'h23);
    rd(20'h00002, v); chk("R8 lock bit clear", v, 8'h00);
    rd(20'h00005, v); chk("R8 other", v, 8'h00);
    wr(20'h12345, 8'hF0);
    chk("R9 single F0 exit", id_active, 0);
    rd(20'h00000, v); chk("R8 off when not id", v, 8'h00);

    // R5: lock
    six(8'h40);
    chk("R5 locked", boot_locked, 1);
    unlock(); wr(20'h05555, 8'h90);
    rd(20'h00002, v); chk("R8 lock bit set", v, 8'h01);
    unlock(); wr(20'h05555, 8'hF0);
    chk("R9 full exit", id_active, 0);

    // R6
    p0 = prog_cnt;
    prog(20'h00100, 8'h44);
    chk("R6 locked dropped", prog_cnt - p0, 0);
    prog(20'h04000, 8'h45);
    chk("R6 outside sector", prog_cnt - p0, 1);
    lock_override = 1;
    prog(20'h00200, 8'h46);
    chk("R6 override allows", prog_cnt - p0, 2);
    chk("R6 override addr", last_pa, 20'h00200);
    p0 = erase_cnt;
    six(8'h10);
    chk("R4 keep with override", last_keep, 0);
    lock_override = 0;
    prog(20'h00300, 8'h47);
    chk("R6 lock back", last_pa, 20'h00200);
    six(8'h10);
    chk("R4 keep locked", last_keep, 1);
    chk("R4 erase count", erase_cnt - p0, 2);
    chk("R5 still locked", boot_locked, 1);

    // R1: power-on reset clears lock and id mode
    unlock(); wr(20'h05555, 8'h90);
    tick(); rst_n = 0;
    tick();
    chk("R1 lock cleared", boot_locked, 0);
    chk("R1 id cleared", id_active, 0);
    tick(); rst_n = 1;
    repeat (3) tick();
    chk("R1 no req", prog_req | erase_req, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule